// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Loader

This block takes the three-wire programming stream of a frequency synthesizer (a serial data line, a shift clock and a load-enable line) and turns it into the divider settings the synthesizer counters use. Both serial wires and load-enable are brought into the system clock domain through two-stage synchronizers. Each synchronized rising edge of the shift clock moves one data bit into a single 19-bit shift register. The word is sent most-significant bit first, so the last bit shifted sits in bit 0 and acts as a steering bit.

When load-enable rises, the steering bit decides which holding register takes the frame. A steering bit of 1 updates the reference register, which holds a 14-bit reference ratio and a modulus-select bit. A steering bit of 0 updates the main register, which holds the 7-bit swallow count and the 11-bit main count. Load-enable is modelled with a pull-up: when the host does not drive the line, the block treats it as high. A frame that would program an illegal ratio is rejected and an error pulse is raised instead. Each accepted transfer raises a one-cycle update strobe.

Top module: `synth_loader`

## Requirements
- R1: After reset the reference ratio is 8, the modulus-select bit is 0 (modulus 128), the swallow count is 0, the main count is 16, and `upd_stb`, `upd_ref` and `err_stb` are 0.
- R2: Each synchronized rising edge of `ser_clk` shifts `ser_dat` into bit 0 of the shift register, and every older bit moves up one place. The first bit sent therefore ends up most significant, and the last bit sent is the steering bit in bit 0.
- R3: On a load with steering bit 1, the reference ratio takes frame bits 14:1 (bit 1 is the LSB) and the modulus-select bit takes frame bit 15. Frame bits 18:16 are ignored.
- R4: On a load with steering bit 0, the swallow count takes frame bits 7:1 and the main count takes frame bits 18:8.
- R5: `modulus` reads 64 when the modulus-select bit is 1 and 128 when it is 0.
- R6: While `ser_le_drv` is 0 the load-enable line counts as high, whatever `ser_le` carries.
- R7: A load happens once per rising edge of the effective load-enable. If the new level is presented before clock edge k, the registers change at edge k+2. No other event changes them, and that includes shifting while load-enable is held high.
- R8: Every accepted load raises `upd_stb` for exactly one clock, in the cycle after the registers change. During that pulse `upd_ref` is 1 for a reference load and 0 for a main load.
- R9: A reference load whose ratio is below 8 leaves every register unchanged and raises `err_stb` for one clock instead of `upd_stb`.
- R10: A main load whose main count is below 16 leaves every register unchanged and raises `err_stb` for one clock instead of `upd_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load-enable level from the host |
| ser_le_drv | input | 1 | 1 when the host drives load-enable; 0 means the line floats high |
| ref_div | output | 14 | Latched reference ratio |
| mod_sw | output | 1 | Latched modulus-select bit |
| modulus | output | 8 | Prescaler modulus value, 64 or 128 |
| swallow_a | output | 7 | Latched swallow count |
| count_n | output | 11 | Latched main count |
| upd_stb | output | 1 | One-cycle pulse after an accepted transfer |
| upd_ref | output | 1 | Tells which register took the transfer flagged by `upd_stb` (1 = reference) |
| err_stb | output | 1 | One-cycle pulse after a rejected transfer |

## Verification
On every cycle the assertions check that the legal ranges of the latched ratios hold, that the registers stay stable unless a load event occurs, that every load event yields exactly one pulse (update or error, never both), and that the modulus output follows the select bit. What the assertions cannot show is that the right frame bits land in the right fields, that the bit order is most significant first, and that a floating load-enable line loads. Only the bench shows these. It shifts concrete words, compares against its own cycle model on every clock, and probes the boundary ratios 7, 8, 15, 16, 2047 and 16383.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;

  localparam int REF_W   = 14;
  localparam int SWA_W   = 7;
  localparam int CNT_W   = 11;
  localparam int SHIFT_W = 1 + SWA_W + CNT_W;
  localparam int REF_MIN = 8;
  localparam int CNT_MIN = 16;
  localparam int MOD_W   = 8;

  typedef struct packed {
    logic             sw;
    logic [REF_W-1:0] ratio;
  } ref_word_t;

  typedef struct packed {
    logic [CNT_W-1:0] n;
    logic [SWA_W-1:0] a;
  } main_word_t;

  // steering bit sits in frame bit 0
  function automatic logic frame_is_ref(input logic [SHIFT_W-1:0] f);
    return f[0];
  endfunction

  // reference frame: ratio in bits REF_W:1, select bit just above it
  function automatic ref_word_t unpack_ref(input logic [SHIFT_W-1:0] f);
    ref_word_t w;
    w.ratio = f[REF_W:1];
    w.sw    = f[REF_W+1];
    return w;
  endfunction

  // main frame: swallow in bits SWA_W:1, main count above it
  function automatic main_word_t unpack_main(input logic [SHIFT_W-1:0] f);
    main_word_t w;
    w.a = f[SWA_W:1];
    w.n = f[SWA_W+CNT_W:SWA_W+1];
    return w;
  endfunction

  function automatic logic ref_legal(input logic [REF_W-1:0] r);
    return int'(r) >= REF_MIN;
  endfunction

  function automatic logic main_legal(input logic [CNT_W-1:0] n);
    return int'(n) >= CNT_MIN;
  endfunction

  function automatic logic [MOD_W-1:0] modulus_of(input logic sw);
    return sw ? MOD_W'(64) : MOD_W'(128);
  endfunction

endpackage

// File: rtl/synth_edge_sync.sv
module synth_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/synth_shifter.sv
module synth_shifter #(
  parameter int WIDTH = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] frame
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame <= '0;
    else if (shift_en) frame <= {frame[WIDTH-2:0], bit_in};
  end
endmodule

// File: rtl/synth_latch.sv
module synth_latch
  import synth_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_evt,
  input  logic [SHIFT_W-1:0] frame,
  output ref_word_t          ref_q,
  output main_word_t         main_q,
  output logic               upd_stb,
  output logic               upd_ref,
  output logic               err_stb
);
  ref_word_t  ref_w;
  main_word_t main_w;
  logic       is_ref;
  logic       accept;

  always_comb begin
    ref_w  = unpack_ref(frame);
    main_w = unpack_main(frame);
    is_ref = frame_is_ref(frame);
    accept = is_ref ? ref_legal(ref_w.ratio) : main_legal(main_w.n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q.ratio <= REF_W'(REF_MIN);
      ref_q.sw    <= 1'b0;
      main_q.a    <= '0;
      main_q.n    <= CNT_W'(CNT_MIN);
      upd_stb     <= 1'b0;
      upd_ref     <= 1'b0;
      err_stb     <= 1'b0;
    end else begin
      upd_stb <= 1'b0;
      upd_ref <= 1'b0;
      err_stb <= 1'b0;
      if (load_evt) begin
        if (accept) begin
          if (is_ref) ref_q  <= ref_w;
          else        main_q <= main_w;
          upd_stb <= 1'b1;
          upd_ref <= is_ref;
        end else begin
          err_stb <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synth_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_le,
  input  logic             ser_le_drv,
  output logic [REF_W-1:0] ref_div,
  output logic             mod_sw,
  output logic [MOD_W-1:0] modulus,
  output logic [SWA_W-1:0] swallow_a,
  output logic [CNT_W-1:0] count_n,
  output logic             upd_stb,
  output logic             upd_ref,
  output logic             err_stb
);
  logic               le_eff;
  logic               sclk_lvl, shift_evt;
  logic               dat_lvl, dat_rise;
  logic               le_lvl, load_evt;
  logic [SHIFT_W-1:0] frame;
  ref_word_t          ref_q;
  main_word_t         main_q;

  // a floating load-enable line reads high (pull-up)
  assign le_eff = ser_le_drv ? ser_le : 1'b1;

  synth_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .din(ser_clk), .lvl(sclk_lvl), .rise(shift_evt));

  synth_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .din(ser_dat), .lvl(dat_lvl), .rise(dat_rise));

  synth_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_le (
    .clk(clk), .rst_n(rst_n), .din(le_eff), .lvl(le_lvl), .rise(load_evt));

  synth_shifter #(.WIDTH(SHIFT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_evt), .bit_in(dat_lvl), .frame(frame));

  synth_latch u_latch (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .frame(frame),
    .ref_q(ref_q), .main_q(main_q),
    .upd_stb(upd_stb), .upd_ref(upd_ref), .err_stb(err_stb));

  assign ref_div   = ref_q.ratio;
  assign mod_sw    = ref_q.sw;
  assign modulus   = modulus_of(ref_q.sw);
  assign swallow_a = main_q.a;
  assign count_n   = main_q.n;
endmodule

// File: rtl/synth_loader_chk.sv
module synth_loader_chk
  import synth_loader_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             load_evt,
  input logic             shift_evt,
  input logic [REF_W-1:0] ref_div,
  input logic             mod_sw,
  input logic [MOD_W-1:0] modulus,
  input logic [SWA_W-1:0] swallow_a,
  input logic [CNT_W-1:0] count_n,
  input logic             upd_stb,
  input logic             upd_ref,
  input logic             err_stb
);
  // R9 and R10: latched ratios never fall below their minimums
  a_r9_ref_floor: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ref_div) >= REF_MIN);
  a_r10_cnt_floor: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_n) >= CNT_MIN);

  // R7: without a load event the registers hold
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(ref_div) && $stable(mod_sw) &&
                   $stable(swallow_a) && $stable(count_n)));

  // R8: each load event gives exactly one outcome pulse
  a_r8_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (upd_stb ^ err_stb));
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> (!upd_stb && !err_stb));
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);
  a_r8_ref_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ref |-> upd_stb);

  // R5: modulus tracks the select bit
  a_r5_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    (modulus == MOD_W'(64)) == mod_sw);
endmodule

bind synth_loader synth_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .shift_evt(shift_evt),
  .ref_div(ref_div), .mod_sw(mod_sw), .modulus(modulus),
  .swallow_a(swallow_a), .count_n(count_n),
  .upd_stb(upd_stb), .upd_ref(upd_ref), .err_stb(err_stb));

// File: tb/synth_loader_test.sv
module synth_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, ser_le_drv = 1'b1;
  logic [13:0] ref_div;
  logic        mod_sw;
  logic [7:0]  modulus;
  logic [6:0]  swallow_a;
  logic [10:0] count_n;
  logic        upd_stb, upd_ref, err_stb;

  int tests = 0, fails = 0, cyc = 0;
  int stb_cnt = 0, err_cnt = 0, refstb_cnt = 0;

  always #4 clk = ~clk;

  synth_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_le(ser_le), .ser_le_drv(ser_le_drv), .ref_div(ref_div), .mod_sw(mod_sw),
    .modulus(modulus), .swallow_a(swallow_a), .count_n(count_n),
    .upd_stb(upd_stb), .upd_ref(upd_ref), .err_stb(err_stb));

  // behavioural reference model: delay queues of input samples, integer frame
  int q_clk[$], q_dat[$], q_le[$];
  int m_frame = 0, m_r = 8, m_sw = 0, m_a = 0, m_n = 16, m_stb = 0, m_ref = 0, m_err = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q_clk = {0, 0, 0}; q_dat = {0, 0, 0}; q_le = {0, 0, 0};
      m_frame = 0; m_r = 8; m_sw = 0; m_a = 0; m_n = 16;
      m_stb = 0; m_ref = 0; m_err = 0;
    end else begin
      // q[1] is the value after two sampling stages, q[2] one clock older
      m_stb = 0; m_ref = 0; m_err = 0;
      if (q_le[1] == 1 && q_le[2] == 0) begin
        if (m_frame % 2 == 1) begin
          if (((m_frame / 2) % 16384) >= 8) begin
            m_r = (m_frame / 2) % 16384; m_sw = (m_frame / 32768) % 2;
            m_stb = 1; m_ref = 1;
          end else m_err = 1;
        end else begin
          if ((m_frame / 256) % 2048 >= 16) begin
            m_a = (m_frame / 2) % 128; m_n = (m_frame / 256) % 2048; m_stb = 1;
          end else m_err = 1;
        end
      end
      if (q_clk[1] == 1 && q_clk[2] == 0)
        m_frame = (m_frame * 2 + q_dat[1]) % 524288;
      void'(q_clk.pop_back()); q_clk.push_front(int'(ser_clk));
      void'(q_dat.pop_back()); q_dat.push_front(int'(ser_dat));
      void'(q_le.pop_back());
      q_le.push_front(ser_le_drv ? int'(ser_le) : 1);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 ratio", int'(ref_div), m_r);
      chk("R3 select", int'(mod_sw), m_sw);
      chk("R4 swallow", int'(swallow_a), m_a);
      chk("R4 count", int'(count_n), m_n);
      chk("R5 modulus", int'(modulus), m_sw ? 64 : 128);
      chk("R8 strobe", int'(upd_stb), m_stb);
      chk("R8 which", int'(upd_ref), m_ref);
      chk("R9/R10 error", int'(err_stb), m_err);
      if (upd_stb) stb_cnt++;
      if (upd_stb && upd_ref) refstb_cnt++;
      if (err_stb) err_cnt++;
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int value, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_dat = value[i];
      wait_clk(4); ser_clk = 1'b1;
      wait_clk(4); ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_le();
    ser_le = 1'b1; wait_clk(6); ser_le = 1'b0; wait_clk(6);
  endtask

  function automatic int ref_frame(input int r, input int sw);
    return (sw * 32768) + (r * 2) + 1;
  endfunction

  function automatic int main_frame(input int a, input int n);
    return (n * 256) + (a * 2);
  endfunction

  task automatic expect_regs(input string tag, input int r, input int sw, input int a, input int n);
    chk({tag, " ratio"}, int'(ref_div), r);
    chk({tag, " select"}, int'(mod_sw), sw);
    chk({tag, " swallow"}, int'(swallow_a), a);
    chk({tag, " count"}, int'(count_n), n);
  endtask

  initial begin : watchdog
    wait_clk(150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s0, e0, rs0;
    wait_clk(5);
    // R1 reset values
    expect_regs("R1", 8, 0, 0, 16);
    chk("R1 modulus", int'(modulus), 128);
    chk("R1 strobes", int'(upd_stb) + int'(err_stb) + int'(upd_ref), 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R2 R3 R5 R8: reference load, select 1
    s0 = stb_cnt; rs0 = refstb_cnt;
    send(ref_frame(100, 1), 16); pulse_le();
    expect_regs("R3", 100, 1, 0, 16);
    chk("R5 modulus 64", int'(modulus), 64);
    chk("R8 one strobe", stb_cnt - s0, 1);
    chk("R8 ref strobe", refstb_cnt - rs0, 1);

    // R2 R4: main load with asymmetric bit pattern
    s0 = stb_cnt; rs0 = refstb_cnt;
    send(main_frame(5, 1234), 19); pulse_le();
    expect_regs("R4", 100, 1, 5, 1234);
    chk("R8 main strobe not ref", refstb_cnt - rs0, 0);

    // R3 R5 boundary ratio 8, select 0; extra high bits ignored
    send(7 * 65536 + ref_frame(8, 0), 19); pulse_le();
    expect_regs("R3 min", 8, 0, 5, 1234);
    chk("R5 modulus 128", int'(modulus), 128);

    // R3 maximum ratio
    send(ref_frame(16383, 1), 16); pulse_le();
    expect_regs("R3 max", 16383, 1, 5, 1234);

    // R9 ratio 7 rejected
    s0 = stb_cnt; e0 = err_cnt;
    send(ref_frame(7, 0), 16); pulse_le();
    expect_regs("R9 hold", 16383, 1, 5, 1234);
    chk("R9 err pulse", err_cnt - e0, 1);
    chk("R9 no strobe", stb_cnt - s0, 0);

    // R4 boundaries: count 16 with swallow 127, count 2047
    send(main_frame(127, 16), 19); pulse_le();
    expect_regs("R4 min", 16383, 1, 127, 16);
    send(main_frame(0, 2047), 19); pulse_le();
    expect_regs("R4 max", 16383, 1, 0, 2047);

    // R10 count 15 rejected
    e0 = err_cnt;
    send(main_frame(3, 15), 19); pulse_le();
    expect_regs("R10 hold", 16383, 1, 0, 2047);
    chk("R10 err pulse", err_cnt - e0, 1);

    // R7 shifting with load-enable low changes nothing
    s0 = stb_cnt;
    send(main_frame(9, 99), 19); wait_clk(6);
    expect_regs("R7 no load", 16383, 1, 0, 2047);
    chk("R7 no strobe", stb_cnt - s0, 0);

    // R7 load-enable held high: one load, none while shifting further
    ser_le = 1'b1; wait_clk(6);
    expect_regs("R7 level load", 16383, 1, 9, 99);
    s0 = stb_cnt;
    send(ref_frame(500, 0), 16); wait_clk(6);
    expect_regs("R7 held high", 16383, 1, 9, 99);
    chk("R7 held strobes", stb_cnt - s0, 0);
    ser_le = 1'b0; wait_clk(6);

    // R6 undriven load-enable counts as high
    s0 = stb_cnt;
    send(ref_frame(321, 0), 16);
    ser_le_drv = 1'b0; wait_clk(6);
    expect_regs("R6 float load", 321, 0, 9, 99);
    chk("R6 strobe", stb_cnt - s0, 1);
    ser_le_drv = 1'b1; wait_clk(6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule